// File: doc/BRIEF.md
# Protection Register and Block Lock Controller

This block guards the nonvolatile array of a serial two-wire memory. It keeps the protection register, which sits at the all-ones word address. The register holds two volatile write-enable latches and three nonvolatile bits: two lock bits that select the protected address range, and a hardware-protect enable. The nonvolatile bits are modelled as flops that keep their value through a soft power-up pulse and clear only on the hard reset.

A serial command sequencer drives the block. It reports start and stop conditions, each data byte of a write transaction together with its word address, each register read, and the end of every internal write cycle. For each data byte the block answers in the same cycle: acknowledge or not, and whether the byte may enter the array's page buffer. At a stop it applies any pending register command and pulses a request for a nonvolatile write cycle when one is needed. Changing the lock bits or the hardware-protect enable takes a three-step sequence with exact data encodings. The register value is always available for reads.

Top module: `wp_guard`

## Requirements
- R1: Hard reset clears every register bit. A power-up pulse clears both latches and keeps the lock bits and the protect enable. The register reads as {enable, 0, 0, lock[1], lock[0], reg-latch, write-latch, 0}, from bit 7 down to bit 0.
- R2: A register write of 8'h02 sets the write latch at the stop, without requesting a write cycle.
- R3: A register write of 8'h06 sets the register latch at the stop only when the write latch is already set. Otherwise it changes nothing.
- R4: While the register latch is set, a register write whose bit 2 is 0 and bit 1 is 1 loads bit 7 into the enable and bits 4:3 into the lock bits at the stop. It also pulses the write-cycle request in the stop cycle. The register latch clears when the write cycle completes.
- R5: While the register latch is set, a register write with bit 2 set changes nothing.
- R6: A register write of 8'h00 clears the write latch only while the register latch is clear. While the register latch is set, the write latch stays set.
- R7: A register data byte with any of bits 6, 5 or 0 set is not acknowledged and has no effect.
- R8: A register write takes one data byte. A second data byte in the same transaction is not acknowledged.
- R9: While the write latch is clear, a data byte to an array address is not acknowledged.
- R10: Lock bits 00 protect nothing, 01 protect 0xC00-0xFFF, 10 protect 0x800-0xFFF and 11 protect the whole array. An array byte in a protected range is acknowledged but not written, and its stop does not request a write cycle. An unprotected byte is written, and its stop requests one.
- R11: When the protect pin is high and the enable bit is set, a step-three register commit is dropped: no write-cycle request and no change. The volatile latches can still be written. With the pin low the commit proceeds.
- R12: A start condition before the stop that would end step three drops the commit and leaves the register latch set.
- R13: Completion of an array write cycle clears the register latch.
- R14: A read of the register address pulses the address-counter clear in the same cycle. A read of any other address does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous; clears everything |
| pwr_up | input | 1 | Soft power-up pulse; clears the volatile latches |
| wp_pin | input | 1 | External write-protect pin |
| start_ev | input | 1 | Start condition seen on the bus |
| stop_ev | input | 1 | Stop condition seen on the bus |
| data_ev | input | 1 | A write data byte has been received |
| data_addr | input | ADDR_W | Word address of that data byte |
| data_byte | input | 8 | The data byte |
| rd_ev | input | 1 | A read byte is being fetched |
| rd_addr | input | ADDR_W | Word address of the read |
| wc_done | input | 1 | The internal nonvolatile write cycle has finished |
| data_ack | output | 1 | Acknowledge the current data byte |
| arr_wr_ok | output | 1 | The current byte may enter the array page buffer |
| nv_start | output | 1 | Request a nonvolatile write cycle, in the stop cycle |
| cnt_clr | output | 1 | Clear the address counter after a register read |
| reg_value | output | 8 | Current protection register value |

## Verification
The bench walks the three-step sequence in and out of order. It targets four mistakes. A design that skips the write-latch check on step two would set the register latch from a cold state. One that lets 8'h00 clear the write latch while the register latch is set would break the order of the latches. One that ignores bit 2 in step three would commit data it should refuse. One that applies the command at the data byte, not at the stop, would commit even when a start aborts it. Each lock setting is probed on both sides of its boundary address, and the commit is tried with the pin high and low. A power-up pulse must keep the lock bits, which catches a design that resets its nonvolatile flops with the latches.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam logic [7:0] RESV_MASK    = 8'b0110_0001;
  localparam logic [7:0] CMD_SET_WEL  = 8'b0000_0010;
  localparam logic [7:0] CMD_SET_RWEL = 8'b0000_0110;
  localparam logic [7:0] CMD_CLR_WEL  = 8'b0000_0000;

  typedef struct packed {
    logic       wpen;
    logic [1:0] bl;
    logic       rwel;
    logic       wel;
  } prot_t;

  function automatic logic [7:0] f_pack(prot_t p);
    return {p.wpen, 2'b00, p.bl, p.rwel, p.wel, 1'b0};
  endfunction

  // quad: the two top bits of the array address
  function automatic logic f_locked(logic [1:0] bl, logic [1:0] quad);
    case (bl)
      2'b00:   return 1'b0;
      2'b01:   return quad == 2'b11;
      2'b10:   return quad[1];
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/wp_lock_decode.sv
module wp_lock_decode
  import wp_pkg::*;
(
  input  logic [1:0] bl,
  input  logic [1:0] quad,
  output logic       locked
);
  assign locked = f_locked(bl, quad);
endmodule

// File: rtl/wp_access_check.sv
module wp_access_check
  import wp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int ARR_W  = 12
) (
  input  logic              data_ev,
  input  logic [ADDR_W-1:0] data_addr,
  input  logic [7:0]        data_byte,
  input  logic              first,
  input  prot_t             st,
  output logic              is_reg,
  output logic              reg_take,
  output logic              arr_locked,
  output logic              ack,
  output logic              arr_ok
);
  logic resv_bad;

  assign is_reg   = &data_addr;
  assign resv_bad = |(data_byte & RESV_MASK);

  wp_lock_decode u_lock (
    .bl     (st.bl),
    .quad   (data_addr[ARR_W-1 -: 2]),
    .locked (arr_locked)
  );

  assign reg_take = data_ev && is_reg && first && !resv_bad;
  assign ack      = is_reg ? reg_take : (data_ev && st.wel);
  assign arr_ok   = data_ev && !is_reg && st.wel && !arr_locked;
endmodule

// File: rtl/wp_state.sv
module wp_state
  import wp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_up,
  input  logic       wp_pin,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic       data_ev,
  input  logic       wc_done,
  input  logic       reg_take,
  input  logic       arr_ok,
  input  logic [7:0] data_byte,
  output prot_t      st,
  output logic       first,
  output logic       reg_commit,
  output logic       nv_start
);
  logic       pend_reg, pend_arr;
  logic [7:0] pend_byte;
  logic       hw_block;

  assign hw_block   = wp_pin && st.wpen;
  assign reg_commit = stop_ev && pend_reg && st.rwel && !pend_byte[2]
                      && pend_byte[1] && !hw_block;
  assign nv_start   = (stop_ev && pend_arr) || reg_commit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= '0;
      first     <= 1'b1;
      pend_reg  <= 1'b0;
      pend_arr  <= 1'b0;
      pend_byte <= '0;
    end else if (pwr_up) begin
      st.wel    <= 1'b0;
      st.rwel   <= 1'b0;
      first     <= 1'b1;
      pend_reg  <= 1'b0;
      pend_arr  <= 1'b0;
    end else begin
      if (start_ev || stop_ev) begin
        first    <= 1'b1;
        pend_reg <= 1'b0;
        pend_arr <= 1'b0;
      end else if (data_ev) begin
        first <= 1'b0;
        if (reg_take) begin
          pend_reg  <= 1'b1;
          pend_byte <= data_byte;
        end
        if (arr_ok) pend_arr <= 1'b1;
      end
      if (wc_done) st.rwel <= 1'b0;
      if (stop_ev && pend_reg) begin
        if (st.rwel) begin
          if (reg_commit) begin
            st.wpen <= pend_byte[7];
            st.bl   <= pend_byte[4:3];
          end
        end else begin
          case (pend_byte)
            CMD_SET_WEL:  st.wel <= 1'b1;
            CMD_SET_RWEL: if (st.wel) st.rwel <= 1'b1;
            CMD_CLR_WEL:  st.wel <= 1'b0;
            default:      ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int ARR_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_up,
  input  logic              wp_pin,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              data_ev,
  input  logic [ADDR_W-1:0] data_addr,
  input  logic [7:0]        data_byte,
  input  logic              rd_ev,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wc_done,
  output logic              data_ack,
  output logic              arr_wr_ok,
  output logic              nv_start,
  output logic              cnt_clr,
  output logic [7:0]        reg_value
);
  prot_t st;
  logic  first, is_reg, reg_take, arr_locked, reg_commit;

  wp_access_check #(.ADDR_W(ADDR_W), .ARR_W(ARR_W)) u_acc (
    .data_ev    (data_ev),
    .data_addr  (data_addr),
    .data_byte  (data_byte),
    .first      (first),
    .st         (st),
    .is_reg     (is_reg),
    .reg_take   (reg_take),
    .arr_locked (arr_locked),
    .ack        (data_ack),
    .arr_ok     (arr_wr_ok)
  );

  wp_state u_st (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_up     (pwr_up),
    .wp_pin     (wp_pin),
    .start_ev   (start_ev),
    .stop_ev    (stop_ev),
    .data_ev    (data_ev),
    .wc_done    (wc_done),
    .reg_take   (reg_take),
    .arr_ok     (arr_wr_ok),
    .data_byte  (data_byte),
    .st         (st),
    .first      (first),
    .reg_commit (reg_commit),
    .nv_start   (nv_start)
  );

  assign cnt_clr   = rd_ev && (&rd_addr);
  assign reg_value = f_pack(st);
endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wp_pin,
  input logic              stop_ev,
  input logic              data_ev,
  input logic [ADDR_W-1:0] data_addr,
  input logic [7:0]        data_byte,
  input logic              rd_ev,
  input logic              data_ack,
  input logic              arr_wr_ok,
  input logic              nv_start,
  input logic              cnt_clr,
  input logic              reg_commit,
  input logic [7:0]        reg_value
);
  AST_RESV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_value[6:5] == 2'b00 && !reg_value[0]);                              // R1
  AST_RWEL_HOLDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    reg_value[2] |-> reg_value[1]);                                        // R6
  AST_NV_ONLY_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    nv_start |-> stop_ev);                                                 // R4
  AST_RESV_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ev && (&data_addr) && (data_byte & 8'h61) != 8'h00) |-> !data_ack); // R7
  AST_NO_WEL_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ev && !(&data_addr) && !reg_value[1]) |-> !data_ack);            // R9
  AST_FULL_LOCK_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_value[4:3] == 2'b11) |-> !arr_wr_ok);                             // R10
  AST_HW_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_pin && reg_value[7]) |-> !reg_commit);                             // R11
  AST_HW_BITS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_pin && reg_value[7]) |=> $stable(reg_value[7:3]));                  // R11
  AST_CLR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |-> rd_ev);                                                    // R14
endmodule

bind wp_guard wp_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wp_pin     (wp_pin),
  .stop_ev    (stop_ev),
  .data_ev    (data_ev),
  .data_addr  (data_addr),
  .data_byte  (data_byte),
  .rd_ev      (rd_ev),
  .data_ack   (data_ack),
  .arr_wr_ok  (arr_wr_ok),
  .nv_start   (nv_start),
  .cnt_clr    (cnt_clr),
  .reg_commit (reg_commit),
  .reg_value  (reg_value)
);

// File: tb/wp_guard_bench.sv
module wp_guard_bench;
  localparam int S_ACK = 0, S_ARR = 1, S_NV = 2, S_REG = 3, S_CLR = 4;
  localparam logic [15:0] RA = 16'hFFFF;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, pwr_up = 1'b0, wp_pin = 1'b0;
  logic start_ev = 1'b0, stop_ev = 1'b0, data_ev = 1'b0, rd_ev = 1'b0, wc_done = 1'b0;
  logic [15:0] data_addr = '0, rd_addr = '0;
  logic [7:0]  data_byte = '0;
  logic data_ack, arr_wr_ok, nv_start, cnt_clr;
  logic [7:0] reg_value;

  wp_guard u_wp_guard (
    .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up), .wp_pin(wp_pin),
    .start_ev(start_ev), .stop_ev(stop_ev), .data_ev(data_ev),
    .data_addr(data_addr), .data_byte(data_byte), .rd_ev(rd_ev),
    .rd_addr(rd_addr), .wc_done(wc_done), .data_ack(data_ack),
    .arr_wr_ok(arr_wr_ok), .nv_start(nv_start), .cnt_clr(cnt_clr),
    .reg_value(reg_value)
  );

  typedef struct { string tag; int sel; logic [7:0] exp; int at; } item_t;
  item_t q[$];
  int cyc = 0, cur = 0, n_chk = 0, n_err = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] observe(int sel);
    case (sel)
      S_ACK:   return {7'd0, data_ack};
      S_ARR:   return {7'd0, arr_wr_ok};
      S_NV:    return {7'd0, nv_start};
      S_CLR:   return {7'd0, cnt_clr};
      default: return reg_value;
    endcase
  endfunction

  // monitor: pops and compares at the falling edge of the due cycle
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].at <= cyc) begin
        it = q.pop_front();
        n_chk++;
        if (observe(it.sel) !== it.exp) begin
          n_err++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel,
                   observe(it.sel), it.exp);
        end
      end
    end
  end

  task automatic chk(string tag, int sel, logic [7:0] exp, int at);
    item_t it;
    it.tag = tag; it.sel = sel; it.exp = exp; it.at = at;
    q.push_back(it);
  endtask

  task automatic clr_in();
    start_ev = 0; stop_ev = 0; data_ev = 0; rd_ev = 0; wc_done = 0; pwr_up = 0;
  endtask
  task automatic t_idle();  @(posedge clk); #2; clr_in(); cur = cyc; endtask
  task automatic t_start(); @(posedge clk); #2; clr_in(); start_ev = 1; cur = cyc; endtask
  task automatic t_stop();  @(posedge clk); #2; clr_in(); stop_ev = 1; cur = cyc; endtask
  task automatic t_wc();    @(posedge clk); #2; clr_in(); wc_done = 1; cur = cyc; endtask
  task automatic t_pwr();   @(posedge clk); #2; clr_in(); pwr_up = 1; cur = cyc; endtask
  task automatic t_data(logic [15:0] a, logic [7:0] b);
    @(posedge clk); #2; clr_in(); data_ev = 1; data_addr = a; data_byte = b; cur = cyc;
  endtask
  task automatic t_rd(logic [15:0] a);
    @(posedge clk); #2; clr_in(); rd_ev = 1; rd_addr = a; cur = cyc;
  endtask

  // register write; expected ack, write-cycle request, and value after the stop
  task automatic reg_wr(string tag, logic [7:0] b, logic ack_e, logic nv_e, logic [7:0] reg_e);
    t_start();
    t_data(RA, b);  chk(tag, S_ACK, {7'd0, ack_e}, cur);
    t_stop();       chk(tag, S_NV, {7'd0, nv_e}, cur); chk(tag, S_REG, reg_e, cur + 1);
    t_idle();
  endtask

  task automatic arr_wr(string tag, logic [15:0] a, logic ack_e, logic ok_e, logic nv_e);
    t_start();
    t_data(a, 8'h5A); chk(tag, S_ACK, {7'd0, ack_e}, cur); chk(tag, S_ARR, {7'd0, ok_e}, cur);
    t_stop();         chk(tag, S_NV, {7'd0, nv_e}, cur);
    t_idle();
    if (nv_e) t_wc();
    t_idle();
  endtask

  task automatic finish_run();
    repeat (3) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    t_idle(); chk("R1 reset value", S_REG, 8'h00, cur);
    arr_wr("R9 array write without write latch", 16'h0010, 0, 0, 0);
    reg_wr("R7 reserved bits set", 8'h03, 0, 0, 8'h00);
    reg_wr("R3 step two without write latch", 8'h06, 1, 0, 8'h00);
    reg_wr("R2 set write latch", 8'h02, 1, 0, 8'h02);
    arr_wr("R10 no lock array write", 16'h0123, 1, 1, 1);
    reg_wr("R3 set reg latch", 8'h06, 1, 0, 8'h06);
    reg_wr("R6 clear blocked by reg latch", 8'h00, 1, 0, 8'h06);
    reg_wr("R5 step three with bit2 set", 8'h0E, 1, 0, 8'h06);
    // R12: start in place of stop
    t_start();
    t_data(RA, 8'h8A); chk("R12 abort byte ack", S_ACK, 8'h01, cur);
    t_start();
    t_stop(); chk("R12 abort no request", S_NV, 8'h00, cur);
    chk("R12 reg latch kept", S_REG, 8'h06, cur + 1);
    t_idle();
    // R4 commit with a second byte (R8)
    t_start();
    t_data(RA, 8'h8A); chk("R4 commit byte ack", S_ACK, 8'h01, cur);
    t_data(RA, 8'h00); chk("R8 second register byte", S_ACK, 8'h00, cur);
    t_stop(); chk("R4 commit request", S_NV, 8'h01, cur);
    chk("R4 bits loaded", S_REG, 8'h8E, cur + 1);
    t_wc(); chk("R4 reg latch cleared on done", S_REG, 8'h8A, cur + 1);
    t_idle();
    arr_wr("R10 lock 01 at C00", 16'h0C00, 1, 0, 0);
    arr_wr("R10 lock 01 at BFF", 16'h0BFF, 1, 1, 1);
    reg_wr("R6 clear write latch", 8'h00, 1, 0, 8'h88);
    reg_wr("R2 set write latch again", 8'h02, 1, 0, 8'h8A);
    wp_pin = 1;
    reg_wr("R11 volatile under pin", 8'h06, 1, 0, 8'h8E);
    reg_wr("R11 commit blocked by pin", 8'h9A, 1, 0, 8'h8E);
    wp_pin = 0;
    reg_wr("R11 commit with pin low", 8'h12, 1, 1, 8'h16);
    t_wc(); chk("R11 after done", S_REG, 8'h12, cur + 1);
    t_idle();
    // lock 10 boundary
    t_start();
    t_data(16'h0800, 8'h11); chk("R10 lock 10 at 800", S_ARR, 8'h00, cur);
    chk("R10 locked byte acked", S_ACK, 8'h01, cur);
    t_data(16'h07FF, 8'h22); chk("R10 lock 10 at 7FF", S_ARR, 8'h01, cur);
    t_stop(); chk("R10 mixed request", S_NV, 8'h01, cur);
    t_wc(); t_idle();
    t_pwr(); chk("R1 power-up keeps lock", S_REG, 8'h10, cur + 1);
    t_idle();
    reg_wr("R13 set write latch", 8'h02, 1, 0, 8'h12);
    reg_wr("R13 set reg latch", 8'h06, 1, 0, 8'h16);
    arr_wr("R13 array write", 16'h0100, 1, 1, 1);
    chk("R13 reg latch cleared", S_REG, 8'h12, cur);
    reg_wr("R4 set reg latch", 8'h06, 1, 0, 8'h16);
    reg_wr("R4 commit full lock", 8'h1A, 1, 1, 8'h1E);
    t_wc(); t_idle(); chk("R4 full lock value", S_REG, 8'h1A, cur);
    arr_wr("R10 lock 11 at 000", 16'h0000, 1, 0, 0);
    t_rd(RA);         chk("R14 register read clears", S_CLR, 8'h01, cur);
    t_rd(16'h0005);   chk("R14 array read", S_CLR, 8'h00, cur);
    t_idle();
    repeat (3) t_idle();
    done = 1;
    finish_run();
  end
endmodule